// File: doc/BRIEF.md
# Picture-in-Picture Window Controller

This block produces the timing and addresses for a small inset picture that is kept in a field buffer and shown over the main picture. It has a write side and a read side. The write side follows the sub-picture's own sync. It decimates incoming 6-bit luma and colour-difference samples in both directions, by 3 for a one-ninth inset or by 4 for a one-sixteenth inset. It writes the kept samples into two simple synchronous RAM ports: one holds luma, the other holds colour-difference pairs at one sixth of the luma rate. A freeze input blocks every write, so the last stored field stays on screen.

The read side follows the main-picture sync. It counts pixels from each rising edge of horizontal sync and counts lines from each vertical sync. It places a rectangle one stored sample wide per clock at one of four fixed corners. Inside that rectangle it issues buffer read addresses and raises a window-enable output. It can also replace the rectangle's outer ring with a border of programmable luma. The window is shown only while the external display-enable input is high.

Top module: `pip_window_ctrl`

## Requirements
- R1: After a rising edge of sub vertical sync, the first rising edge of sub horizontal sync starts source line 0. With size_sel=0 (one-ninth), source lines 0,3,6,… are kept, and on each kept line the valid samples 0,3,6,… are kept. With size_sel=1 (one-sixteenth) the step is 4 for both lines and samples. A valid sample in the same cycle as a sync edge is ignored.
- R2: A kept sample of stored line L and stored column C writes its Y value to luma address L*W+C, with luma_we high, on the clock after the sample is taken. Samples past column W-1 of a line are not written.
- R3: The number of stored lines per field is limited to LINES_L (69) with size_sel=0 and LINES_S (52) with size_sel=1. Later source lines write nothing, and the luma store of W*LINES_L 6-bit words together with the chroma store fits in 96 kbit.
- R4: A kept sample whose column C is a multiple of 6 also writes chroma_wdata = {B-Y[11:6], R-Y[5:0]} to chroma address L*ceil(W/6)+C/6, in the same cycle as its luma write.
- R5: While freeze is high, neither store is written. The read side keeps displaying the previously stored field.
- R6: A rising edge of main horizontal sync makes the next clock pixel column 0. After a rising edge of main vertical sync, the first horizontal sync edge starts main line 0. Before any sync is seen after reset, no window is shown.
- R7: corner_sel bit 0 selects the right side and bit 1 selects the bottom. The window's left column is H_MARGIN or H_ACTIVE-H_MARGIN-W. Its top line is V_MARGIN or V_ACTIVE-V_MARGIN-height, where height is LINES_L or LINES_S according to size_sel.
- R8: win_en is high for exactly the W columns and the height lines of the rectangle. It lags the pixel counter by one clock, so pixel column c appears two clocks after the clock of the sync edge plus c. pip_y, pip_cb and pip_cr are 0 whenever win_en is low.
- R9: Inside the rectangle, at row r and column c, the read addresses are r*W+c for luma and r*ceil(W/6)+c/6 for chroma. The pixel outputs carry the RAM read data returned one clock later.
- R10: With frame_on=1, the two leftmost columns, the two rightmost columns, and the top and bottom rows of the window output Y=border_luma and B-Y=R-Y=32. With frame_on=0 they show stored data.
- R11: While disp_en is low, win_en stays low and the pixel outputs are 0.
- R12: After reset, luma_we, chroma_we and win_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4fsc) |
| rst | input | 1 | Synchronous active-high reset |
| size_sel | input | 1 | 0 = one-ninth inset, 1 = one-sixteenth inset |
| corner_sel | input | 2 | bit0 right side, bit1 bottom side |
| frame_on | input | 1 | Enable the border ring |
| border_luma | input | 6 | Luma value of the border |
| freeze | input | 1 | Block all buffer writes |
| sub_hsync | input | 1 | Sub-picture horizontal sync, rising edge used |
| sub_vsync | input | 1 | Sub-picture vertical sync, active high |
| sub_valid | input | 1 | Sub-picture sample strobe |
| sub_y | input | 6 | Sub-picture luma sample |
| sub_cb | input | 6 | Sub-picture B-Y sample |
| sub_cr | input | 6 | Sub-picture R-Y sample |
| main_hsync | input | 1 | Main-picture horizontal sync, rising edge used |
| main_vsync | input | 1 | Main-picture vertical sync, active high |
| disp_en | input | 1 | External display enable, high shows the inset |
| luma_we | output | 1 | Luma store write enable |
| luma_waddr | output | LA_W | Luma store write address |
| luma_wdata | output | 6 | Luma store write data |
| chroma_we | output | 1 | Chroma store write enable |
| chroma_waddr | output | CA_W | Chroma store write address |
| chroma_wdata | output | 12 | Chroma store write data {B-Y, R-Y} |
| luma_raddr | output | LA_W | Luma store read address |
| luma_rdata | input | 6 | Luma store read data, one clock after address |
| chroma_raddr | output | CA_W | Chroma store read address |
| chroma_rdata | input | 12 | Chroma store read data, one clock after address |
| win_en | output | 1 | Inset window active |
| pip_y | output | 6 | Inset luma output |
| pip_cb | output | 6 | Inset B-Y output |
| pip_cr | output | 6 | Inset R-Y output |

## Verification
The bench writes fields in both sizes with more source lines and samples than fit. A controller that gets the line or sample step wrong, or that misses the line or column limit, produces an extra or shifted write, and the write scoreboard reports it. It scans the main raster at all four corners, with the frame on and off, and checks every pixel. A corner formula that is off by one, a wrong latency, or a border drawn one ring too wide or too narrow shows up as a wrong win_en or a wrong pixel value. A frozen field with new data must produce no write at all, and the following scan must still show the older picture. A scan with display disabled must stay dark.

// File: rtl/pip_pkg.sv
package pip_pkg;

    localparam int PIX_W      = 6;
    localparam int CRATIO     = 6;
    localparam int FRAME_COLS = 2;
    localparam logic [PIX_W-1:0] CHROMA_NEUTRAL = 6'd32;
    localparam int BUFFER_BITS = 96 * 1024;

    typedef enum logic [1:0] {
        CORNER_TL = 2'b00,
        CORNER_TR = 2'b01,
        CORNER_BL = 2'b10,
        CORNER_BR = 2'b11
    } corner_e;

    typedef enum logic {
        SIZE_NINTH     = 1'b0,
        SIZE_SIXTEENTH = 1'b1
    } size_e;

    typedef struct packed {
        logic [PIX_W-1:0] y;
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] cr;
    } pixel_t;

    typedef struct packed {
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] cr;
    } chroma_t;

    function automatic int chroma_cols(input int w);
        return (w + CRATIO - 1) / CRATIO;
    endfunction

    function automatic logic [1:0] decim_last(input size_e s);
        return (s == SIZE_NINTH) ? 2'd2 : 2'd3;
    endfunction

    function automatic int stored_lines(input size_e s, input int l_large, input int l_small);
        return (s == SIZE_NINTH) ? l_large : l_small;
    endfunction

    function automatic logic is_right(input corner_e c);
        return (c == CORNER_TR) || (c == CORNER_BR);
    endfunction

    function automatic logic is_bottom(input corner_e c);
        return (c == CORNER_BL) || (c == CORNER_BR);
    endfunction

    function automatic int store_bits(input int w, input int lines);
        return lines * (w * PIX_W + chroma_cols(w) * 2 * PIX_W);
    endfunction

endpackage

// File: rtl/pip_rise.sv
module pip_rise (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/pip_wr_ctrl.sv
module pip_wr_ctrl
    import pip_pkg::*;
#(
    parameter int W       = 171,
    parameter int LINES_L = 69,
    parameter int LINES_S = 52,
    parameter int LA_W    = 14,
    parameter int CA_W    = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_rise,
    input  logic             vs_rise,
    input  logic             valid,
    input  pixel_t           pix_in,
    input  logic             freeze,
    input  size_e            size,
    output logic             luma_we,
    output logic [LA_W-1:0]  luma_addr,
    output logic [PIX_W-1:0] luma_wdata,
    output logic             chroma_we,
    output logic [CA_W-1:0]  chroma_addr,
    output chroma_t          chroma_wdata
);
    localparam int CW   = chroma_cols(W);
    localparam int LN_W = $clog2(LINES_L + 1);
    localparam int CL_W = $clog2(W + 1);
    localparam logic [LN_W-1:0] LINE_STOP = LN_W'(LINES_L);

    logic             first;
    logic [1:0]       lph;
    logic [1:0]       sph;
    logic [LN_W-1:0]  wline;
    logic [CL_W-1:0]  wcol;
    logic [1:0]       last_ph;
    int               lines_n;
    logic             line_kept;
    logic             take;

    always_comb begin
        last_ph   = decim_last(size);
        lines_n   = stored_lines(size, LINES_L, LINES_S);
        line_kept = !first && (lph == 2'd0) && (int'(wline) < lines_n);
        take      = valid && !hs_rise && !vs_rise && line_kept
                    && (sph == 2'd0) && (int'(wcol) < W);
    end

    // line and sample decimation state
    always_ff @(posedge clk) begin
        if (rst) begin
            first <= 1'b1;
            lph   <= 2'd0;
            sph   <= 2'd0;
            wline <= LINE_STOP;
            wcol  <= '0;
        end else if (vs_rise) begin
            first <= 1'b1;
            lph   <= 2'd0;
            sph   <= 2'd0;
            wline <= '0;
            wcol  <= '0;
        end else if (hs_rise) begin
            sph  <= 2'd0;
            wcol <= '0;
            if (first) begin
                first <= 1'b0;
            end else begin
                if (lph == 2'd0 && wline != LINE_STOP) wline <= wline + LN_W'(1);
                lph <= (lph >= last_ph) ? 2'd0 : lph + 2'd1;
            end
        end else if (valid) begin
            sph <= (sph >= last_ph) ? 2'd0 : sph + 2'd1;
            if (sph == 2'd0 && int'(wcol) < W) wcol <= wcol + CL_W'(1);
        end
    end

    // registered write ports
    always_ff @(posedge clk) begin
        if (rst) begin
            luma_we      <= 1'b0;
            chroma_we    <= 1'b0;
            luma_addr    <= '0;
            chroma_addr  <= '0;
            luma_wdata   <= '0;
            chroma_wdata <= '0;
        end else begin
            luma_we      <= take && !freeze;
            chroma_we    <= take && !freeze && ((int'(wcol) % CRATIO) == 0);
            luma_addr    <= LA_W'(int'(wline) * W + int'(wcol));
            chroma_addr  <= CA_W'(int'(wline) * CW + int'(wcol) / CRATIO);
            luma_wdata   <= pix_in.y;
            chroma_wdata <= '{cb: pix_in.cb, cr: pix_in.cr};
        end
    end

    assert_luma_bound_R3: assert property (@(posedge clk) disable iff (rst)
        luma_we |-> (int'(luma_addr) < W * LINES_L));

    assert_chroma_bound_R3: assert property (@(posedge clk) disable iff (rst)
        chroma_we |-> (int'(chroma_addr) < CW * LINES_L));

    assert_chroma_with_luma_R4: assert property (@(posedge clk) disable iff (rst)
        chroma_we |-> luma_we);

    assert_freeze_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        (freeze && $past(freeze)) |-> (!luma_we && !chroma_we));
endmodule

// File: rtl/pip_rd_ctrl.sv
module pip_rd_ctrl
    import pip_pkg::*;
#(
    parameter int W        = 171,
    parameter int LINES_L  = 69,
    parameter int LINES_S  = 52,
    parameter int H_ACTIVE = 760,
    parameter int V_ACTIVE = 240,
    parameter int H_MARGIN = 24,
    parameter int V_MARGIN = 12,
    parameter int HC_W     = 10,
    parameter int VC_W     = 9,
    parameter int LA_W     = 14,
    parameter int CA_W     = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_rise,
    input  logic             vs_rise,
    input  logic             disp_en,
    input  size_e            size,
    input  corner_e          corner,
    input  logic             frame_on,
    input  logic [PIX_W-1:0] border_y,
    input  logic [PIX_W-1:0] luma_rdata,
    input  chroma_t          chroma_rdata,
    output logic [LA_W-1:0]  luma_raddr,
    output logic [CA_W-1:0]  chroma_raddr,
    output logic             win_en,
    output pixel_t           pix_out
);
    localparam int CW = chroma_cols(W);
    localparam logic [HC_W-1:0] H_SAT = '1;
    localparam logic [VC_W-1:0] V_SAT = '1;

    logic [HC_W-1:0] hcnt;
    logic [VC_W-1:0] vcnt;
    logic            vfirst;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt   <= H_SAT;
            vcnt   <= V_SAT;
            vfirst <= 1'b0;
        end else begin
            if (hs_rise)             hcnt <= '0;
            else if (hcnt != H_SAT)  hcnt <= hcnt + HC_W'(1);

            if (vs_rise) begin
                vcnt   <= '0;
                vfirst <= 1'b1;
            end else if (hs_rise) begin
                if (vfirst)             vfirst <= 1'b0;
                else if (vcnt != V_SAT) vcnt   <= vcnt + VC_W'(1);
            end
        end
    end

    int   x0, y0, hgt, col, row;
    logic in_rect, on_edge;

    always_comb begin
        hgt     = stored_lines(size, LINES_L, LINES_S);
        x0      = is_right(corner)  ? (H_ACTIVE - H_MARGIN - W)   : H_MARGIN;
        y0      = is_bottom(corner) ? (V_ACTIVE - V_MARGIN - hgt) : V_MARGIN;
        col     = int'(hcnt) - x0;
        row     = int'(vcnt) - y0;
        in_rect = (col >= 0) && (col < W) && (row >= 0) && (row < hgt);
        on_edge = (col < FRAME_COLS) || (col >= W - FRAME_COLS) || (row == 0) || (row == hgt - 1);
        luma_raddr   = in_rect ? LA_W'(row * W + col) : '0;
        chroma_raddr = in_rect ? CA_W'(row * CW + col / CRATIO) : '0;
    end

    logic win_q, brd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
            brd_q <= 1'b0;
        end else begin
            win_q <= in_rect && disp_en;
            brd_q <= in_rect && disp_en && frame_on && on_edge;
        end
    end

    always_comb begin
        if (!win_q)     pix_out = '0;
        else if (brd_q) pix_out = '{y: border_y, cb: CHROMA_NEUTRAL, cr: CHROMA_NEUTRAL};
        else            pix_out = '{y: luma_rdata, cb: chroma_rdata.cb, cr: chroma_rdata.cr};
    end

    assign win_en = win_q;

    assert_blank_outside_R8: assert property (@(posedge clk) disable iff (rst)
        !win_en |-> (pix_out == '0));

    assert_disp_gate_R11: assert property (@(posedge clk) disable iff (rst)
        !disp_en |=> !win_en);

    assert_raddr_bound_R9: assert property (@(posedge clk) disable iff (rst)
        in_rect |-> (int'(luma_raddr) < W * hgt));
endmodule

// File: rtl/pip_window_ctrl.sv
module pip_window_ctrl
    import pip_pkg::*;
#(
    parameter int W        = 171,
    parameter int LINES_L  = 69,
    parameter int LINES_S  = 52,
    parameter int H_ACTIVE = 760,
    parameter int V_ACTIVE = 240,
    parameter int H_MARGIN = 24,
    parameter int V_MARGIN = 12,
    parameter int HC_W     = 10,
    parameter int VC_W     = 9,
    localparam int LA_W    = $clog2(W * LINES_L),
    localparam int CA_W    = $clog2(((W + 5) / 6) * LINES_L)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            size_sel,
    input  logic [1:0]      corner_sel,
    input  logic            frame_on,
    input  logic [5:0]      border_luma,
    input  logic            freeze,
    input  logic            sub_hsync,
    input  logic            sub_vsync,
    input  logic            sub_valid,
    input  logic [5:0]      sub_y,
    input  logic [5:0]      sub_cb,
    input  logic [5:0]      sub_cr,
    input  logic            main_hsync,
    input  logic            main_vsync,
    input  logic            disp_en,
    output logic            luma_we,
    output logic [LA_W-1:0] luma_waddr,
    output logic [5:0]      luma_wdata,
    output logic            chroma_we,
    output logic [CA_W-1:0] chroma_waddr,
    output logic [11:0]     chroma_wdata,
    output logic [LA_W-1:0] luma_raddr,
    input  logic [5:0]      luma_rdata,
    output logic [CA_W-1:0] chroma_raddr,
    input  logic [11:0]     chroma_rdata,
    output logic            win_en,
    output logic [5:0]      pip_y,
    output logic [5:0]      pip_cb,
    output logic [5:0]      pip_cr
);
    localparam int NSYNC = 4;
    localparam int TOTAL_BITS = store_bits(W, LINES_L);

    logic [NSYNC-1:0] sync_in, sync_rise;
    assign sync_in = {main_vsync, main_hsync, sub_vsync, sub_hsync};

    for (genvar i = 0; i < NSYNC; i++) begin : g_edge
        pip_rise u_rise (.clk(clk), .rst(rst), .sig(sync_in[i]), .rise(sync_rise[i]));
    end

    size_e   size;
    corner_e corner;
    pixel_t  sub_pix, out_pix;
    chroma_t cw_data;

    assign size    = size_e'(size_sel);
    assign corner  = corner_e'(corner_sel);
    assign sub_pix = '{y: sub_y, cb: sub_cb, cr: sub_cr};

    pip_wr_ctrl #(
        .W(W), .LINES_L(LINES_L), .LINES_S(LINES_S), .LA_W(LA_W), .CA_W(CA_W)
    ) u_wr (
        .clk(clk), .rst(rst),
        .hs_rise(sync_rise[0]), .vs_rise(sync_rise[1]),
        .valid(sub_valid), .pix_in(sub_pix),
        .freeze(freeze), .size(size),
        .luma_we(luma_we), .luma_addr(luma_waddr), .luma_wdata(luma_wdata),
        .chroma_we(chroma_we), .chroma_addr(chroma_waddr), .chroma_wdata(cw_data)
    );

    assign chroma_wdata = cw_data;

    pip_rd_ctrl #(
        .W(W), .LINES_L(LINES_L), .LINES_S(LINES_S),
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE),
        .H_MARGIN(H_MARGIN), .V_MARGIN(V_MARGIN),
        .HC_W(HC_W), .VC_W(VC_W), .LA_W(LA_W), .CA_W(CA_W)
    ) u_rd (
        .clk(clk), .rst(rst),
        .hs_rise(sync_rise[2]), .vs_rise(sync_rise[3]),
        .disp_en(disp_en), .size(size), .corner(corner),
        .frame_on(frame_on), .border_y(border_luma),
        .luma_rdata(luma_rdata), .chroma_rdata(chroma_t'(chroma_rdata)),
        .luma_raddr(luma_raddr), .chroma_raddr(chroma_raddr),
        .win_en(win_en), .pix_out(out_pix)
    );

    assign pip_y  = out_pix.y;
    assign pip_cb = out_pix.cb;
    assign pip_cr = out_pix.cr;

    // storage budget for the default geometry (R3)
    initial begin
        if (TOTAL_BITS > BUFFER_BITS)
            $display("pip_window_ctrl: store of %0d bits exceeds buffer (R3)", TOTAL_BITS);
    end

    assert_reset_quiet_R12: assert property (@(posedge clk)
        $past(rst) |-> (!luma_we && !chroma_we && !win_en));
endmodule

// File: tb/sim_pip_window_ctrl.sv
module sim_pip_window_ctrl;
    localparam int W = 8, LL = 6, LS = 4, HA = 30, VA = 20, HM = 2, VM = 1;
    localparam int CW = 2, LINE = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic       size_sel = 0, frame_on = 0, freeze = 0, disp_en = 1;
    logic [1:0] corner_sel = 0;
    logic [5:0] border_luma = 0;
    logic       sub_hsync = 0, sub_vsync = 0, sub_valid = 0;
    logic [5:0] sub_y = 0, sub_cb = 0, sub_cr = 0;
    logic       main_hsync = 0, main_vsync = 0;
    logic       luma_we, chroma_we, win_en;
    logic [5:0] luma_waddr, luma_raddr;
    logic [3:0] chroma_waddr, chroma_raddr;
    logic [5:0] luma_wdata, luma_rdata, pip_y, pip_cb, pip_cr;
    logic [11:0] chroma_wdata, chroma_rdata;

    pip_window_ctrl #(.W(W), .LINES_L(LL), .LINES_S(LS), .H_ACTIVE(HA), .V_ACTIVE(VA),
                      .H_MARGIN(HM), .V_MARGIN(VM), .HC_W(6), .VC_W(5)) u0 (
        .clk(clk), .rst(rst), .size_sel(size_sel), .corner_sel(corner_sel),
        .frame_on(frame_on), .border_luma(border_luma), .freeze(freeze),
        .sub_hsync(sub_hsync), .sub_vsync(sub_vsync), .sub_valid(sub_valid),
        .sub_y(sub_y), .sub_cb(sub_cb), .sub_cr(sub_cr),
        .main_hsync(main_hsync), .main_vsync(main_vsync), .disp_en(disp_en),
        .luma_we(luma_we), .luma_waddr(luma_waddr), .luma_wdata(luma_wdata),
        .chroma_we(chroma_we), .chroma_waddr(chroma_waddr), .chroma_wdata(chroma_wdata),
        .luma_raddr(luma_raddr), .luma_rdata(luma_rdata),
        .chroma_raddr(chroma_raddr), .chroma_rdata(chroma_rdata),
        .win_en(win_en), .pip_y(pip_y), .pip_cb(pip_cb), .pip_cr(pip_cr));

    // synchronous RAM models
    logic [5:0]  lmem [0:W*LL-1];
    logic [11:0] cmem [0:CW*LL-1];
    always @(posedge clk) begin
        if (luma_we && int'(luma_waddr) < W*LL) lmem[luma_waddr] <= luma_wdata;
        if (chroma_we && int'(chroma_waddr) < CW*LL) cmem[chroma_waddr] <= chroma_wdata;
        luma_rdata   <= (int'(luma_raddr) < W*LL) ? lmem[luma_raddr] : 6'd0;
        chroma_rdata <= (int'(chroma_raddr) < CW*LL) ? cmem[chroma_raddr] : 12'd0;
    end

    int vectors = 0, miscompares = 0;
    bit done = 0;
    int luma_q[$];
    int chroma_q[$];
    int exp_luma [0:W*LL-1];
    int exp_chroma [0:CW*LL-1];
    string wtag = "R1 R2";

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // write-side monitor: pops the scoreboard on every write
    always @(negedge clk) begin
        if (!rst && luma_we) begin
            if (luma_q.size() == 0) chk({wtag, " unexpected luma write"}, int'(luma_waddr), -1);
            else chk({wtag, " luma write"}, int'(luma_waddr)*256 + int'(luma_wdata), luma_q.pop_front());
        end
        if (!rst && chroma_we) begin
            if (chroma_q.size() == 0) chk("R4 R5 unexpected chroma write", int'(chroma_waddr), -1);
            else chk("R4 chroma write", int'(chroma_waddr)*4096 + int'(chroma_wdata), chroma_q.pop_front());
        end
    end

    // write driver: one sub field, pushes expected writes
    task automatic write_field(input bit mode, input bit frz, input int seed);
        int d  = mode ? 4 : 3;
        int h  = mode ? LS : LL;
        int nl = h*d + 2;
        int ns = W*d + 3;
        size_sel = mode; freeze = frz;
        sub_vsync = 1; @(posedge clk); #1 sub_vsync = 0;
        for (int l = 0; l < nl; l++) begin
            sub_hsync = 1; @(posedge clk); #1 sub_hsync = 0;
            for (int k = 0; k < ns; k++) begin
                int y  = (l*7 + k + seed) & 63;
                int cb = (k + 3 + seed) & 63;
                int cr = (l + k*5) & 63;
                sub_valid = 1; sub_y = 6'(y); sub_cb = 6'(cb); sub_cr = 6'(cr);
                if (!frz && l % d == 0 && l/d < h && k % d == 0 && k/d < W) begin
                    int a = (l/d)*W + k/d;
                    luma_q.push_back(a*256 + y);
                    exp_luma[a] = y;
                    if ((k/d) % 6 == 0) begin
                        int ca = (l/d)*CW + (k/d)/6;
                        chroma_q.push_back(ca*4096 + cb*64 + cr);
                        exp_chroma[ca] = cb*64 + cr;
                    end
                end
                @(posedge clk); #1;
            end
            sub_valid = 0;
        end
        repeat (3) @(posedge clk); #1;
        chk("R3 luma writes left over", luma_q.size(), 0);
        chk("R4 chroma writes left over", chroma_q.size(), 0);
        freeze = 0;
    endtask

    // main raster scan with per-pixel checks
    task automatic scan_field(input string tag);
        int h  = size_sel ? LS : LL;
        int x0 = corner_sel[0] ? (HA - HM - W) : HM;
        int y0 = corner_sel[1] ? (VA - VM - h) : VM;
        main_vsync = 1; @(posedge clk); #1 main_vsync = 0;
        for (int v = 0; v < VA; v++) begin
            main_hsync = 1; @(posedge clk); #1 main_hsync = 0;
            @(posedge clk);
            for (int p = 0; p < LINE; p++) begin
                int c = p - x0, r = v - y0;
                bit inr = (c >= 0 && c < W && r >= 0 && r < h);
                bit ew = inr && disp_en;
                int ey = 0, ecb = 0, ecr = 0;
                if (ew) begin
                    if (frame_on && (c < 2 || c >= W-2 || r == 0 || r == h-1)) begin
                        ey = border_luma; ecb = 32; ecr = 32;
                    end else begin
                        ey = exp_luma[r*W + c];
                        ecb = exp_chroma[r*CW + c/6] >> 6;
                        ecr = exp_chroma[r*CW + c/6] & 63;
                    end
                end
                @(negedge clk);
                chk({tag, " R6 R7 R8 win_en"}, int'(win_en), int'(ew));
                chk({tag, " R9 R10 pixel"}, int'({pip_y, pip_cb, pip_cr}), ey*4096 + ecb*64 + ecr);
            end
            @(posedge clk); #1;
        end
    endtask

    initial begin
        for (int i = 0; i < W*LL; i++) exp_luma[i] = 0;
        for (int i = 0; i < CW*LL; i++) exp_chroma[i] = 0;
        repeat (3) @(posedge clk); #1 rst = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R12 reset win_en", int'(win_en), 0);
            chk("R12 reset writes", int'(luma_we) + int'(chroma_we), 0);
        end
        @(posedge clk); #1;
        wtag = "R1 R2 ninth";
        write_field(1'b0, 1'b0, 0);
        corner_sel = 2'b00; frame_on = 0; scan_field("ninth TL");
        corner_sel = 2'b11; frame_on = 1; border_luma = 6'd45; scan_field("ninth BR frame");
        wtag = "R1 R2 sixteenth";
        write_field(1'b1, 1'b0, 5);
        corner_sel = 2'b01; frame_on = 0; scan_field("sixteenth TR");
        corner_sel = 2'b10; frame_on = 1; border_luma = 6'd9; scan_field("sixteenth BL frame");
        wtag = "R5 frozen";
        write_field(1'b1, 1'b1, 11);
        corner_sel = 2'b00; frame_on = 0; scan_field("R5 frozen display");
        disp_en = 0; scan_field("R11 disabled");
        disp_en = 1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(4*200000);
        if (!done) begin
            vectors++; miscompares++;
            $display("FAIL watchdog R12 act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule